// File: doc/BRIEF.md
# Serial Wire Debug Host Read Engine

This block is the host side of a two-wire debug link. It makes the serial debug clock from the system clock through a divider that software or a wrapper sets per command. It also drives the bidirectional data line through a separate value output and an output enable, so that a pad cell outside the block can release the line. A single start pulse begins one read of a debug-port or access-port register. If `reset_first` is set, the read begins with a line reset and idle bits. The engine then sends the 8-bit request and hands the line to the target for one turnaround bit. It collects the 3-bit acknowledge. After an OK acknowledge it also collects 32 data bits and a parity bit. It then takes the line back and drives two idle-low bits before it reports.

The controller is a state machine. Its states are IDLE, LRST (line held high), LIDLE (line held low), HDR (request bits), TRN_A (first turnaround), ACK, DATA, TRN_B (second turnaround), TAIL (idle-low bits) and FIN. These are the transitions:

- IDLE→LRST is taken on start with reset_first set.
- IDLE→HDR is taken on start without reset_first.
- LRST→LIDLE follows 50 bits.
- LIDLE→HDR follows 2 bits.
- HDR→TRN_A follows 8 bits.
- TRN_A→ACK follows 1 bit.
- ACK→DATA is taken when the acknowledge is OK.
- ACK→TRN_B is taken for any other acknowledge.
- DATA→TRN_B follows 33 bits.
- TRN_B→TAIL follows 1 bit.
- TAIL→FIN follows 2 bits.
- FIN→IDLE is taken on the next falling clock edge, which also pulses done.

Top module: `swd_read_host`

## Requirements
- R1: With reset_first set, the host drives the data line high for 50 serial clocks and then low for 2, before the request. Without it, the first request bit goes out on the first serial clock.
- R2: The request goes out as 8 driven bits in this wire order: start=1, port select (1 = access port), read=1, addr[0], addr[1], even parity over the four bits before it, stop=0, park=1. An identification read (port 0, addr 0) appears as 1,0,1,0,0,1,0,1.
- R3: After the park bit, the output enable is low for exactly one turnaround bit, and it stays low through every acknowledge and data bit.
- R4: The acknowledge is sampled in the order OK, WAIT, FAULT. ack_code bit 0 holds the first wire bit, so OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100. Any other value sets proto_err.
- R5: After an OK acknowledge, exactly 33 target bits are sampled. The first 32 form rdata, least significant bit first.
- R6: The 33rd bit is even parity over the data. A mismatch sets parity_err, which is only ever set with an OK acknowledge.
- R7: For any acknowledge other than OK, the data phase is skipped, rdata reads 0 and parity_err stays 0.
- R8: The last target bit is followed by one released turnaround bit and then 2 bits driven low. done is then high for one system clock, busy falls, and the line stays driven low.
- R9: Each high phase of the serial clock lasts clk_div+1 system clocks, and the serial clock rests low while no transfer runs.
- R10: The data line value and enable change only while the serial clock is low. Target bits are sampled on its rising edge.
- R11: A start pulse that arrives while busy is ignored. The running request keeps its original fields, and no second transfer follows.
- R12: Out of reset, busy, done, swclk and swdio_o are 0 and swdio_oe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| clk_div | input | DIV_W | half-period of the serial clock, minus one, in system clocks |
| start | input | 1 | one-cycle command pulse |
| ap_ndp | input | 1 | 1 selects the access port, 0 the debug port |
| addr | input | 2 | register address bits 3:2 |
| reset_first | input | 1 | precede the request with a line reset |
| swdio_i | input | 1 | data line as seen from the pad |
| swclk | output | 1 | serial debug clock |
| swdio_o | output | 1 | data line value when driven |
| swdio_oe | output | 1 | 1 drives the data line, 0 releases it |
| busy | output | 1 | transfer in progress |
| done | output | 1 | one-cycle completion pulse |
| rdata | output | 32 | read data, 0 unless the acknowledge was OK |
| ack_code | output | 3 | acknowledge bits, first wire bit in bit 0 |
| proto_err | output | 1 | acknowledge not one-hot |
| parity_err | output | 1 | read data parity mismatch |

## Verification
A bench-side target model answers every request. A sweep over all port-select and address pairs checks the request bits and parity against values computed in the bench. The same sweep alternates the line reset and the divider, which separates framing faults from clock-rate faults. The acknowledge is tried as OK, WAIT, FAULT and several non-one-hot codes, including 1,0,1, to tell the data-phase branch from the skip branch and from the error flag. Data words with mixed bits and all zeros, a word of all ones, a corrupted parity bit and a start pulse sent in mid-transfer cover bit order, parity detection and command rejection.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LRST,
        ST_LIDLE,
        ST_HDR,
        ST_TRN_A,
        ST_ACK,
        ST_DATA,
        ST_TRN_B,
        ST_TAIL,
        ST_FIN
    } swd_state_e;

    localparam int ACK_W   = 3;
    localparam int HDR_W   = 8;

    localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

    // Request bits indexed by wire position: index 0 leaves first.
    function automatic logic [HDR_W-1:0] make_request(input logic ap, input logic [1:0] a);
        logic par;
        par = ap ^ 1'b1 ^ a[0] ^ a[1];
        return {1'b1, 1'b0, par, a[1], a[0], 1'b1, ap, 1'b1};
    endfunction

    function automatic logic ack_is_legal(input logic [ACK_W-1:0] code);
        return (code == ACK_OK) || (code == ACK_WAIT) || (code == ACK_FAULT);
    endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             bit_start,
    output logic             bit_sample
);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             first_q;
    logic             wrap;

    assign wrap = (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sclk_q  <= 1'b0;
            first_q <= 1'b1;
        end else if (!en) begin
            cnt_q   <= '0;
            sclk_q  <= 1'b0;
            first_q <= 1'b1;
        end else if (first_q) begin
            first_q <= 1'b0;
            cnt_q   <= '0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign swclk      = sclk_q;
    assign bit_start  = en & (first_q | (wrap & sclk_q));
    assign bit_sample = en & ~first_q & wrap & ~sclk_q;

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !swclk);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_start, bit_sample}));

endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
    parameter int ACK_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ack_en,
    input  logic              data_en,
    input  logic              bit_in,
    output logic [ACK_W-1:0]  ack_now,
    output logic [ACK_W-1:0]  ack_q,
    output logic [DATA_W-1:0] data_word,
    output logic              par_err
);

    localparam int SH_W = DATA_W + 1;

    logic [SH_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= '0;
            sh_q  <= '0;
        end else if (clr) begin
            ack_q <= '0;
            sh_q  <= '0;
        end else begin
            if (ack_en) begin
                ack_q <= ack_now;
            end
            if (data_en) begin
                sh_q <= {bit_in, sh_q[SH_W-1:1]};
            end
        end
    end

    assign ack_now   = {bit_in, ack_q[ACK_W-1:1]};
    assign data_word = sh_q[DATA_W-1:0];
    assign par_err   = (^sh_q[DATA_W-1:0]) ^ sh_q[SH_W-1];

endmodule

// File: rtl/swd_read_ctrl.sv
module swd_read_ctrl
    import swd_pkg::*;
#(
    parameter int RST_LEN  = 50,
    parameter int IDLE_LEN = 2,
    parameter int TAIL_LEN = 2,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ap_ndp,
    input  logic [1:0]        addr,
    input  logic              reset_first,
    input  logic              swclk,
    input  logic              bit_start,
    input  logic              bit_sample,
    input  logic [ACK_W-1:0]  ack_now,
    input  logic [ACK_W-1:0]  ack_q,
    input  logic [DATA_W-1:0] data_word,
    input  logic              par_err,
    output logic              gen_en,
    output logic              cap_clr,
    output logic              ack_en,
    output logic              data_en,
    output logic              swdio_o,
    output logic              swdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ACK_W-1:0]  ack_code,
    output logic              proto_err,
    output logic              parity_err
);

    localparam int DATA_BITS = DATA_W + 1;
    localparam int CNT_MAX   = (RST_LEN > DATA_BITS) ? RST_LEN : DATA_BITS;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_LEN - 1);
    localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_LEN - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(ACK_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W);

    swd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [HDR_W-1:0] hdr_q, hdr_d;
    logic             ack_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hdr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hdr_q   <= hdr_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hdr_d   = hdr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    hdr_d   = make_request(ap_ndp, addr);
                    cnt_d   = '0;
                    state_d = reset_first ? ST_LRST : ST_HDR;
                end
            end
            ST_LRST: begin
                if (bit_sample) begin
                    if (cnt_q == RST_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_LIDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_LIDLE: begin
                if (bit_sample) begin
                    if (cnt_q == IDLE_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_HDR;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (bit_sample) begin
                    if (cnt_q == HDR_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_TRN_A;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_TRN_A: begin
                if (bit_sample) begin
                    cnt_d   = '0;
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                if (bit_sample) begin
                    if (cnt_q == ACK_LAST) begin
                        cnt_d   = '0;
                        state_d = (ack_now == ACK_OK) ? ST_DATA : ST_TRN_B;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_sample) begin
                    if (cnt_q == DATA_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_TRN_B;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_TRN_B: begin
                if (bit_sample) begin
                    cnt_d   = '0;
                    state_d = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (bit_sample) begin
                    if (cnt_q == TAIL_LAST) begin
                        cnt_d   = '0;
                        state_d = ST_FIN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                if (bit_start) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign gen_en  = (state_q != ST_IDLE);
    assign busy    = gen_en;
    assign cap_clr = (state_q == ST_IDLE) & start;
    assign ack_en  = (state_q == ST_ACK)  & bit_sample;
    assign data_en = (state_q == ST_DATA) & bit_sample;
    assign ack_ok  = (ack_q == ACK_OK);

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swdio_o    <= 1'b0;
            swdio_oe   <= 1'b1;
            done       <= 1'b0;
            rdata      <= '0;
            ack_code   <= '0;
            proto_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (bit_start) begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_LRST: begin
                        swdio_oe <= 1'b1;
                        swdio_o  <= 1'b1;
                    end
                    ST_LIDLE, ST_TAIL, ST_FIN: begin
                        swdio_oe <= 1'b1;
                        swdio_o  <= 1'b0;
                    end
                    ST_HDR: begin
                        swdio_oe <= 1'b1;
                        swdio_o  <= hdr_q[cnt_q[2:0]];
                    end
                    ST_TRN_A, ST_ACK, ST_DATA, ST_TRN_B: begin
                        swdio_oe <= 1'b0;
                        swdio_o  <= 1'b0;
                    end
                endcase
            end
            if ((state_q == ST_FIN) && bit_start) begin
                done       <= 1'b1;
                ack_code   <= ack_q;
                rdata      <= ack_ok ? data_word : '0;
                parity_err <= ack_ok & par_err;
                proto_err  <= ~ack_is_legal(ack_q);
            end
        end
    end

    // R10
    dio_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({swdio_oe, swdio_o}) |-> !swclk);

    // R3
    line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_sample && ((state_q == ST_ACK) || (state_q == ST_DATA))) |-> !swdio_oe);

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(hdr_q));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    nonok_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (ack_code != ACK_OK)) |-> ((rdata == '0) && !parity_err));

endmodule

// File: rtl/swd_read_host.sv
module swd_read_host
    import swd_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int RST_LEN  = 50,
    parameter int IDLE_LEN = 2,
    parameter int TAIL_LEN = 2,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              start,
    input  logic              ap_ndp,
    input  logic [1:0]        addr,
    input  logic              reset_first,
    input  logic              swdio_i,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ACK_W-1:0]  ack_code,
    output logic              proto_err,
    output logic              parity_err
);

    logic              gen_en;
    logic              bit_start;
    logic              bit_sample;
    logic              cap_clr;
    logic              ack_en;
    logic              data_en;
    logic [ACK_W-1:0]  ack_now;
    logic [ACK_W-1:0]  ack_q;
    logic [DATA_W-1:0] data_word;
    logic              par_err;

    swd_clk_gen #(
        .DIV_W (DIV_W)
    ) i_clk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (gen_en),
        .div        (clk_div),
        .swclk      (swclk),
        .bit_start  (bit_start),
        .bit_sample (bit_sample)
    );

    swd_rx_capture #(
        .ACK_W  (ACK_W),
        .DATA_W (DATA_W)
    ) i_rx_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cap_clr),
        .ack_en    (ack_en),
        .data_en   (data_en),
        .bit_in    (swdio_i),
        .ack_now   (ack_now),
        .ack_q     (ack_q),
        .data_word (data_word),
        .par_err   (par_err)
    );

    swd_read_ctrl #(
        .RST_LEN  (RST_LEN),
        .IDLE_LEN (IDLE_LEN),
        .TAIL_LEN (TAIL_LEN),
        .DATA_W   (DATA_W)
    ) i_read_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ap_ndp      (ap_ndp),
        .addr        (addr),
        .reset_first (reset_first),
        .swclk       (swclk),
        .bit_start   (bit_start),
        .bit_sample  (bit_sample),
        .ack_now     (ack_now),
        .ack_q       (ack_q),
        .data_word   (data_word),
        .par_err     (par_err),
        .gen_en      (gen_en),
        .cap_clr     (cap_clr),
        .ack_en      (ack_en),
        .data_en     (data_en),
        .swdio_o     (swdio_o),
        .swdio_oe    (swdio_oe),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .ack_code    (ack_code),
        .proto_err   (proto_err),
        .parity_err  (parity_err)
    );

endmodule

// File: tb/test_swd_read_host.sv
`timescale 1ns/1ps
module test_swd_read_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic        start = 1'b0;
    logic        ap_ndp = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        reset_first = 1'b0;
    logic        swdio_i = 1'b0;
    logic        swclk;
    logic        swdio_o;
    logic        swdio_oe;
    logic        busy;
    logic        done;
    logic [31:0] rdata;
    logic [2:0]  ack_code;
    logic        proto_err;
    logic        parity_err;

    int vectors = 0;
    int misses  = 0;

    logic [0:127] resp = '0;
    logic         rec_o  [0:127];
    logic         rec_oe [0:127];
    int           rise_cnt = 0;
    longint       hi_min = 0;
    longint       hi_max = 0;
    int           chg_viol = 0;

    always #10 clk = ~clk;

    swd_read_host i_swd_read_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_div     (clk_div),
        .start       (start),
        .ap_ndp      (ap_ndp),
        .addr        (addr),
        .reset_first (reset_first),
        .swdio_i     (swdio_i),
        .swclk       (swclk),
        .swdio_o     (swdio_o),
        .swdio_oe    (swdio_oe),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .ack_code    (ack_code),
        .proto_err   (proto_err),
        .parity_err  (parity_err)
    );

    task automatic chk(input logic pass, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!pass) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // target model: drives its bit while the serial clock is low
    initial begin
        forever begin
            @(negedge swclk);
            swdio_i <= (rise_cnt < 128) ? resp[rise_cnt] : 1'b0;
        end
    end

    // bit monitor: records the host side of the line after each rising edge
    initial begin
        forever begin
            @(posedge swclk);
            #1;
            if (rise_cnt < 128) begin
                rec_o[rise_cnt]  = swdio_o;
                rec_oe[rise_cnt] = swdio_oe;
            end
            rise_cnt++;
        end
    end

    // high-phase width in system clocks
    initial begin
        forever begin
            longint t0, w;
            @(posedge swclk);
            t0 = longint'($time);
            @(negedge swclk);
            w = (longint'($time) - t0) / 20;
            if (w < hi_min) hi_min = w;
            if (w > hi_max) hi_max = w;
        end
    end

    // line changes while the serial clock is high
    initial begin
        forever begin
            @(swdio_o or swdio_oe);
            #1;
            if (swclk) chg_viol++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    task automatic run_txn(input logic ap, input logic [1:0] a, input logic rf,
                           input logic [7:0] dv, input logic [2:0] ackw,
                           input logic [31:0] d, input logic flip_par, input logic poke);
        int h0;
        int exp_rises;
        int tend;
        int bad;
        logic ok;
        logic legal;
        logic [7:0] req_bits;
        h0    = rf ? 52 : 0;
        ok    = (ackw == 3'b001);
        legal = (ackw == 3'b001) || (ackw == 3'b010) || (ackw == 3'b100);
        req_bits = {1'b1, 1'b0, ap ^ 1'b1 ^ a[0] ^ a[1], a[1], a[0], 1'b1, ap, 1'b1};
        resp = '0;
        for (int k = 0; k < 3; k++) resp[h0 + 9 + k] = ackw[k];
        for (int i = 0; i < 32; i++) resp[h0 + 12 + i] = d[i];
        resp[h0 + 44] = (^d) ^ flip_par;
        for (int i = 0; i < 128; i++) begin
            rec_o[i]  = 1'bx;
            rec_oe[i] = 1'bx;
        end

        @(negedge clk);
        clk_div = dv;
        rise_cnt = 0;
        hi_min = 1000000;
        hi_max = 0;
        chg_viol = 0;
        start = 1'b1; ap_ndp = ap; addr = a; reset_first = rf;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1; ap_ndp = ~ap; addr = ~a; reset_first = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        do begin
            @(posedge clk);
            #1;
        end while (!done);

        exp_rises = h0 + (ok ? 48 : 15);
        // R5 R7: number of serial clocks, 33-bit data phase present only on OK
        chk(rise_cnt == exp_rises, ok ? "R5 bit count" : "R7 bit count", rise_cnt, exp_rises);

        if (rf) begin
            bad = 0;
            for (int i = 0; i < 50; i++) if (!(rec_oe[i] === 1'b1 && rec_o[i] === 1'b1)) bad++;
            // R1: line reset high bits
            chk(bad == 0, "R1 reset high", bad, 0);
            bad = 0;
            for (int i = 50; i < 52; i++) if (!(rec_oe[i] === 1'b1 && rec_o[i] === 1'b0)) bad++;
            chk(bad == 0, "R1 idle low", bad, 0);
        end

        bad = 0;
        for (int j = 0; j < 8; j++) if (!(rec_oe[h0 + j] === 1'b1 && rec_o[h0 + j] === req_bits[j])) bad++;
        // R2: request bits and parity
        chk(bad == 0, "R2 request", {rec_o[h0+7], rec_o[h0+6], rec_o[h0+5], rec_o[h0+4],
                                      rec_o[h0+3], rec_o[h0+2], rec_o[h0+1], rec_o[h0]}, req_bits);

        tend = h0 + (ok ? 45 : 12);
        bad = 0;
        for (int j = h0 + 8; j < tend; j++) if (rec_oe[j] !== 1'b0) bad++;
        // R3: released from turnaround through the last target bit
        chk(bad == 0, "R3 release", bad, 0);

        bad = 0;
        if (rec_oe[tend] !== 1'b0) bad++;
        for (int j = tend + 1; j < tend + 3; j++) if (!(rec_oe[j] === 1'b1 && rec_o[j] === 1'b0)) bad++;
        // R8: turnaround then two driven-low bits
        chk(bad == 0, "R8 tail", bad, 0);

        // R4
        chk(ack_code == ackw, "R4 ack_code", ack_code, ackw);
        chk(proto_err == !legal, "R4 proto_err", proto_err, !legal);
        // R5 R7
        chk(rdata == (ok ? d : 32'd0), ok ? "R5 rdata" : "R7 rdata", rdata, ok ? d : 32'd0);
        // R6
        chk(parity_err == (ok & flip_par), "R6 parity_err", parity_err, ok & flip_par);
        // R9
        chk(hi_min == dv + 1 && hi_max == dv + 1, "R9 high width", {hi_min[31:0], hi_max[31:0]}, dv + 1);
        // R10
        chk(chg_viol == 0, "R10 change while high", chg_viol, 0);

        repeat (4 * (dv + 2)) @(posedge clk);
        #1;
        // R8 R11: idle, line held low, nothing restarted
        chk(!busy && !swclk && swdio_oe && !swdio_o && rise_cnt == exp_rises,
            poke ? "R11 ignored start" : "R8 idle after done",
            {busy, swclk, swdio_oe, swdio_o}, 4'b0010);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R12
        chk(!busy && !done && !swclk && swdio_oe && !swdio_o, "R12 reset state",
            {busy, done, swclk, swdio_oe, swdio_o}, 5'b00010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // identification read with line reset
        run_txn(1'b0, 2'd0, 1'b1, 8'd1, 3'b001, 32'hC0DE5A21, 1'b0, 1'b0);

        // all port/address pairs, alternating reset and divider
        for (int k = 0; k < 8; k++) begin
            run_txn(k[2], k[1:0], k[0] ^ k[2], 8'(k % 3), 3'b001,
                    32'h9E3779B9 * (k + 1), 1'b0, 1'b0);
        end

        // acknowledge classes, legal and not
        run_txn(1'b1, 2'd1, 1'b0, 8'd0, 3'b010, 32'hFFFF0000, 1'b0, 1'b0);
        run_txn(1'b0, 2'd2, 1'b0, 8'd1, 3'b100, 32'h12345678, 1'b0, 1'b0);
        run_txn(1'b0, 2'd0, 1'b1, 8'd0, 3'b101, 32'hAAAA5555, 1'b0, 1'b0);
        run_txn(1'b1, 2'd3, 1'b0, 8'd2, 3'b000, 32'h0F0F0F0F, 1'b0, 1'b0);
        run_txn(1'b0, 2'd1, 1'b0, 8'd0, 3'b111, 32'h00000001, 1'b0, 1'b0);
        run_txn(1'b1, 2'd0, 1'b0, 8'd1, 3'b011, 32'h80000000, 1'b0, 1'b0);

        // parity corruption and extreme data words
        run_txn(1'b1, 2'd2, 1'b0, 8'd1, 3'b001, 32'h13579BDF, 1'b1, 1'b0);
        run_txn(1'b0, 2'd3, 1'b0, 8'd0, 3'b001, 32'h00000000, 1'b0, 1'b0);
        run_txn(1'b0, 2'd1, 1'b0, 8'd3, 3'b001, 32'hFFFFFFFF, 1'b1, 1'b0);

        // start while busy
        run_txn(1'b0, 2'd2, 1'b0, 8'd1, 3'b001, 32'h2468ACE0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule